// File: doc/BRIEF.md
# Indicator LED Sequencer

This block drives a bank of four indicator LEDs on its own, so the processor no longer spends instruction cycles refreshing them. A processor-written mode register picks one of five behaviours. The lights can be blanked. They can show a built-in bouncing pattern, which needs no programming. They can follow processor writes directly, as a latch. In learn mode, processor writes are recorded into a 32-step sequence memory. In replay mode, the recorded steps play back on their own.

Playback and the built-in pattern move forward only on a step-rate tick. That tick comes from an external divider, so the display speed is set outside the block. A separate enable input blanks the lights whatever mode is selected. The recorded sequence survives mode changes and is cleared only when learn mode is entered again.

Top module: `led_seq`

## Requirements
- R1: After reset (rst_ni low, asynchronous), the mode is default, the recorded length is zero, the bounce position is at LED 0, and led_o shows 4'b0001 while enable_i is high.
- R2: led_o is 4'b0000 whenever enable_i is low. It is also 4'b0000 in the off mode (mode code 0) and for the unused mode codes 5, 6 and 7.
- R3: In default mode (code 1), each tick_i moves a single lit LED one place. The sequence runs 0001, 0010, 0100, 1000, 0100, 0010, 0001, 0010 and repeats in the same bouncing way.
- R4: In manual mode (code 2), a pattern write (pat_we_i with pat_i) appears on led_o after the next clock edge and holds until the next write. Ticks do not change it.
- R5: A mode write selecting learn mode (code 3) clears the recorded length. Each pattern write in learn mode then appends one step and shows that pattern on led_o. Writes made after 32 steps are stored are dropped.
- R6: A mode write selecting replay mode (code 4) shows recorded step 0. Each tick_i moves to the next step, and the step after the last recorded one is step 0.
- R7: In replay mode with zero recorded steps, led_o shows the default bouncing pattern, advanced by tick_i.
- R8: Any mode write returns the replay step to 0 and the bounce to LED 0 moving upward. It keeps the recorded sequence unless the new mode is learn.
- R9: Pattern writes in off, default and replay modes are ignored. They change neither led_o nor the recorded sequence.
- R10: In a cycle with a mode write, tick_i and pat_we_i are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Light enable; low blanks all LEDs |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_i | input | 3 | Mode code: 0 off, 1 default, 2 manual, 3 learn, 4 replay |
| pat_we_i | input | 1 | Pattern write strobe |
| pat_i | input | 4 | Pattern data |
| tick_i | input | 1 | Step-rate tick, one cycle wide |
| led_o | output | 4 | LED drive, bit n lights LED n |

## Verification
The assertions assume that the strobes and the tick are synchronous to clk_i and last one cycle each. They also assume that mode_i and pat_i carry known values whenever their strobe is high. The bench drives every input on the falling edge and keeps each strobe high for exactly one cycle. Mode writes that coincide with a tick or a pattern write are applied on purpose, so the same-cycle ordering is exercised inside those input rules.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;
  localparam int unsigned NUM_LED = 4;
  localparam int unsigned DEPTH   = 32;
  localparam int unsigned IDX_W   = $clog2(DEPTH);
  localparam int unsigned LEN_W   = $clog2(DEPTH + 1);
  localparam int unsigned POS_W   = $clog2(NUM_LED);

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_DFLT   = 3'd1,
    MODE_MANUAL = 3'd2,
    MODE_LEARN  = 3'd3,
    MODE_REPLAY = 3'd4
  } mode_e;
endpackage

// File: rtl/led_seq_store.sv
module led_seq_store #(
  parameter int unsigned W     = 4,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [W-1:0]     data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [LEN_W-1:0] len_o,
  output logic [W-1:0]     rd_data_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [LEN_W-1:0] len_q;
  logic             full;

  assign full = (len_q == LEN_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               len_q <= '0;
    else if (clr_i)            len_q <= '0;
    else if (wr_i && !full)    len_q <= len_q + LEN_W'(1);
  end

  // storage has no reset; only indices below len_q are ever read
  always_ff @(posedge clk_i) begin
    if (!clr_i && wr_i && !full) mem_q[len_q[IDX_W-1:0]] <= data_i;
  end

  assign len_o     = len_q;
  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/led_seq_player.sv
module led_seq_player #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [IDX_W-1:0] step_o
);
  logic [IDX_W-1:0] step_q;
  logic             last;

  assign last = ((LEN_W'(step_q) + LEN_W'(1)) >= len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        step_q <= '0;
    else if (restart_i) step_q <= '0;
    else if (adv_i)     step_q <= last ? '0 : step_q + IDX_W'(1);
  end

  assign step_o = step_q;
endmodule

// File: rtl/led_seq_bounce.sv
module led_seq_bounce #(
  parameter int unsigned N = 4,
  localparam int unsigned POS_W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         adv_i,
  output logic [N-1:0] led_o
);
  logic [POS_W-1:0] pos_q;
  logic             up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      up_q  <= 1'b1;
    end else if (restart_i) begin
      pos_q <= '0;
      up_q  <= 1'b1;
    end else if (adv_i) begin
      if (up_q) begin
        if (pos_q == POS_W'(N - 1)) begin
          pos_q <= pos_q - POS_W'(1);
          up_q  <= 1'b0;
        end else begin
          pos_q <= pos_q + POS_W'(1);
        end
      end else begin
        if (pos_q == '0) begin
          pos_q <= POS_W'(1);
          up_q  <= 1'b1;
        end else begin
          pos_q <= pos_q - POS_W'(1);
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign led_o[g] = (pos_q == POS_W'(g));
  end
endmodule

// File: rtl/led_seq.sv
module led_seq
  import led_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               mode_we_i,
  input  logic [2:0]         mode_i,
  input  logic               pat_we_i,
  input  logic [NUM_LED-1:0] pat_i,
  input  logic               tick_i,
  output logic [NUM_LED-1:0] led_o
);
  logic [2:0]         mode_q;
  logic [NUM_LED-1:0] latch_q;
  logic [LEN_W-1:0]   len_w;
  logic [IDX_W-1:0]   step_w;
  logic [NUM_LED-1:0] seq_led;
  logic [NUM_LED-1:0] bounce_led;
  logic               empty;
  logic               pat_ok;
  logic               tick_ok;
  logic               learn_clr;

  assign empty     = (len_w == '0);
  assign pat_ok    = pat_we_i && !mode_we_i;
  assign tick_ok   = tick_i && !mode_we_i;
  assign learn_clr = mode_we_i && (mode_i == MODE_LEARN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_DFLT;
    else if (mode_we_i) mode_q <= mode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else if (pat_ok && (mode_q == MODE_MANUAL || mode_q == MODE_LEARN)) latch_q <= pat_i;
  end

  led_seq_store #(.W(NUM_LED), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (learn_clr),
    .wr_i      (pat_ok && mode_q == MODE_LEARN),
    .data_i    (pat_i),
    .rd_idx_i  (step_w),
    .len_o     (len_w),
    .rd_data_o (seq_led)
  );

  led_seq_player #(.DEPTH(DEPTH)) u_player (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (mode_we_i),
    .adv_i     (tick_ok && mode_q == MODE_REPLAY && !empty),
    .len_i     (len_w),
    .step_o    (step_w)
  );

  led_seq_bounce #(.N(NUM_LED)) u_bounce (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (mode_we_i),
    .adv_i     (tick_ok && (mode_q == MODE_DFLT || (mode_q == MODE_REPLAY && empty))),
    .led_o     (bounce_led)
  );

  always_comb begin
    led_o = '0;
    if (enable_i) begin
      case (mode_q)
        MODE_DFLT:   led_o = bounce_led;
        MODE_MANUAL,
        MODE_LEARN:  led_o = latch_q;
        MODE_REPLAY: led_o = empty ? bounce_led : seq_led;
        default:     led_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/led_seq_chk.sv
module led_seq_chk
  import led_seq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic               mode_we_i,
  input logic               pat_we_i,
  input logic [NUM_LED-1:0] pat_i,
  input logic [2:0]         mode_q,
  input logic [LEN_W-1:0]   len_w,
  input logic [IDX_W-1:0]   step_w,
  input logic [NUM_LED-1:0] led_o
);
  p_blank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> led_o == '0);

  p_one_lit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && mode_q == MODE_DFLT) |-> $countones(led_o) == 1);

  p_manual_show_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_MANUAL && pat_we_i && !mode_we_i) |=>
      (!enable_i || led_o == $past(pat_i)));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_w <= LEN_W'(DEPTH));

  p_len_grow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> (len_w == $past(len_w) || len_w == $past(len_w) + LEN_W'(1)));

  p_step_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_REPLAY && len_w != '0) |-> LEN_W'(step_w) < len_w);

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> step_w == '0);
endmodule

bind led_seq led_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .mode_we_i (mode_we_i),
  .pat_we_i  (pat_we_i),
  .pat_i     (pat_i),
  .mode_q    (mode_q),
  .len_w     (len_w),
  .step_w    (step_w),
  .led_o     (led_o)
);

// File: tb/led_seq_tb.sv
`timescale 1ns/1ps
module led_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       mwe = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       pwe = 1'b0;
  logic [3:0] pat = 4'h0;
  logic       tick = 1'b0;
  logic [3:0] led;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  led_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .mode_we_i(mwe), .mode_i(mode),
    .pat_we_i(pwe), .pat_i(pat), .tick_i(tick), .led_o(led)
  );

  // {req[3:0], mode_we, mode[2:0], pat_we, pat[3:0], tick, en, exp[3:0]}
  localparam int NV = 30;
  localparam logic [18:0] VEC [NV] = '{
    {4'd1, 1'b0,3'd0, 1'b0,4'h0, 1'b0,1'b1, 4'b0001}, // R1 idle after reset
    {4'd3, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b0010}, // R3 bounce
    {4'd3, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b0100},
    {4'd3, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b1000},
    {4'd3, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b0100},
    {4'd3, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b0010},
    {4'd3, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b0001},
    {4'd3, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b0010},
    {4'd2, 1'b0,3'd0, 1'b0,4'h0, 1'b0,1'b0, 4'b0000}, // R2 enable low
    {4'd4, 1'b1,3'd2, 1'b0,4'h0, 1'b0,1'b1, 4'b0000}, // R4 manual, latch reset
    {4'd4, 1'b0,3'd0, 1'b1,4'hA, 1'b0,1'b1, 4'b1010}, // R4 write
    {4'd4, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b1010}, // R4 tick no effect
    {4'd5, 1'b1,3'd3, 1'b0,4'h0, 1'b0,1'b1, 4'b1010}, // R5 enter learn
    {4'd5, 1'b0,3'd0, 1'b1,4'h3, 1'b0,1'b1, 4'b0011},
    {4'd5, 1'b0,3'd0, 1'b1,4'h5, 1'b0,1'b1, 4'b0101},
    {4'd5, 1'b0,3'd0, 1'b1,4'h9, 1'b0,1'b1, 4'b1001},
    {4'd6, 1'b1,3'd4, 1'b0,4'h0, 1'b0,1'b1, 4'b0011}, // R6 replay step0
    {4'd6, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b0101},
    {4'd6, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b1001},
    {4'd6, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b0011}, // R6 wrap
    {4'd9, 1'b0,3'd0, 1'b1,4'hF, 1'b0,1'b1, 4'b0011}, // R9 write in replay
    {4'd9, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b0101}, // R9 seq intact
    {4'd2, 1'b1,3'd0, 1'b0,4'h0, 1'b0,1'b1, 4'b0000}, // R2 off mode
    {4'd2, 1'b1,3'd6, 1'b0,4'h0, 1'b0,1'b1, 4'b0000}, // R2 unused code
    {4'd8, 1'b1,3'd4, 1'b0,4'h0, 1'b0,1'b1, 4'b0011}, // R8 seq kept, step0
    {4'd6, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b0101},
    {4'd10,1'b1,3'd4, 1'b0,4'h0, 1'b1,1'b1, 4'b0011}, // R10 tick ignored on mode write
    {4'd10,1'b1,3'd2, 1'b1,4'h6, 1'b0,1'b1, 4'b1001}, // R10 pat ignored on mode write
    {4'd8, 1'b1,3'd1, 1'b0,4'h0, 1'b0,1'b1, 4'b0001}, // R8 bounce restart
    {4'd3, 1'b0,3'd0, 1'b0,4'h0, 1'b1,1'b1, 4'b0010}
  };

  task automatic check(input int req, input logic [3:0] exp);
    checks++;
    if (led !== exp) begin
      fails++;
      $display("FAIL R%0d led_o=%b expected=%b", req, led, exp);
    end
  endtask

  task automatic cyc(input logic m_we, input logic [2:0] m, input logic p_we,
                     input logic [3:0] p, input logic t, input logic e);
    @(negedge clk);
    mwe = m_we; mode = m; pwe = p_we; pat = p; tick = t; en = e;
    @(posedge clk);
    #1;
    @(negedge clk);
    mwe = 1'b0; pwe = 1'b0; tick = 1'b0;
    #0.5;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    check(1, 4'b0001); // R1 during reset
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][14], VEC[i][13:11], VEC[i][10], VEC[i][9:6], VEC[i][5], VEC[i][4]);
      check(int'(VEC[i][18:15]), VEC[i][3:0]);
    end

    // R7: empty sequence replays the bounce
    cyc(1'b1, 3'd3, 1'b0, 4'h0, 1'b0, 1'b1);
    cyc(1'b1, 3'd4, 1'b0, 4'h0, 1'b0, 1'b1);
    check(7, 4'b0001);
    cyc(1'b0, 3'd0, 1'b0, 4'h0, 1'b1, 1'b1);
    check(7, 4'b0010);

    // R5: fill 32 steps, 33rd write dropped
    cyc(1'b1, 3'd3, 1'b0, 4'h0, 1'b0, 1'b1);
    for (int i = 0; i < 32; i++) cyc(1'b0, 3'd0, 1'b1, 4'(i), 1'b0, 1'b1);
    cyc(1'b0, 3'd0, 1'b1, 4'hE, 1'b0, 1'b1);
    cyc(1'b1, 3'd4, 1'b0, 4'h0, 1'b0, 1'b1);
    check(6, 4'h0);
    for (int i = 0; i < 31; i++) cyc(1'b0, 3'd0, 1'b0, 4'h0, 1'b1, 1'b1);
    check(5, 4'hF); // R5 step 31 holds the 32nd write
    cyc(1'b0, 3'd0, 1'b0, 4'h0, 1'b1, 1'b1);
    check(5, 4'h0); // R5 wraps after 32, extra write not stored

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(1, 4'b0001);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b1, 3'd4, 1'b0, 4'h0, 1'b0, 1'b1);
    check(1, 4'b0001); // R1 length cleared: replay shows bounce

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule